// File: doc/BRIEF.md
# YUV 4:2:2 to RGB Pixel Converter

This block turns an interleaved 4:2:2 byte stream from an image sensor into 24-bit RGB pixels, one per luma sample. Bytes arrive one per accepted cycle in the repeating order luma, blue-difference chroma, luma, red-difference chroma. Two neighbouring luma samples share the chroma pair of their four-byte group, so the block gathers a full group before producing anything. It then emits the two pixels of that group on back-to-back cycles.

For each pixel the converter subtracts the chroma offset and multiplies by fixed-point colour matrix coefficients. It rounds each product, forms the three channel sums and saturates each of them to eight bits. A start-of-frame input forces the byte phase back to the first luma slot, so the stream can be realigned at any frame boundary. A full 352 by 240 frame at two bytes per pixel is 168,960 input bytes long and yields 84,480 pixels.

Top module: `yuv422_rgb_conv`

## Requirements
- R1: Accepted bytes (byte_vld_i high) are assigned to slots in the repeating order Y0, U, Y1, V, and a pixel pair is produced only for a group whose V byte has been accepted.
- R2: For a V byte sampled at clock edge k, pix_vld_o is high after edge k+1 carrying the Y0 pixel and after edge k+2 carrying the Y1 pixel. It is low at every other time, so a valid run is never longer than two cycles.
- R3: Both pixels of a group use that group's U and V bytes, and each uses its own luma byte.
- R4: 128 is subtracted from U and V before multiplication. With 8 fractional bits the coefficients are 359 (1.402), 88 (0.34414), 183 (0.71414) and 454 (1.772). The channels are R = Y + 1.402(V-128), G = Y - 0.34414(U-128) - 0.71414(V-128) and B = Y + 1.772(U-128).
- R5: Each coefficient product is divided by 256 and rounded to the nearest integer, with halves rounding toward plus infinity, before the channel sum is formed.
- R6: Each channel sum is clamped to 0 when negative and to 255 when above 255.
- R7: A byte accepted together with sof_i high is taken as Y0, and any partly gathered group is dropped. sof_i without byte_vld_i makes the next accepted byte a Y0.
- R8: Bytes presented with byte_vld_i low have no effect on the slot order or on any pixel.
- R9: While rst_ni is low, pix_vld_o is low and the byte phase returns to Y0.
- R10: pix_o packs the channels as R in bits 23:16, G in bits 15:8 and B in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start of frame; forces byte phase to Y0 |
| byte_vld_i | input | 1 | Input byte valid |
| byte_i | input | 8 | Input byte in 4:2:2 interleaved order |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_o | output | 24 | RGB pixel, R high byte, B low byte |

## Verification
The pairing and burst-length properties assume that two completed groups are always at least four accepted bytes apart. This follows from the slot order even when sof_i restarts a group, because sof_i can only force a Y0 slot. The properties also assume that the inputs are known once reset is released. The stimulus covers several cases: idle gaps of random length between bytes, with garbage on byte_i; sof_i pulses at every phase, both with and without an accompanying byte; extreme values that drive all three channels to both clamp limits; and long random runs. The reference model predicts each pixel and the exact cycle in which it must appear.

// File: rtl/yuv_rgb_pkg.sv
package yuv_rgb_pkg;

  typedef enum logic [1:0] {
    PH_Y0 = 2'd0,
    PH_U  = 2'd1,
    PH_Y1 = 2'd2,
    PH_V  = 2'd3
  } phase_e;

  // Coefficient given in units of 1e-5, returned rounded to fw fractional bits
  function automatic int q_coef(input int c_e5, input int fw);
    return (c_e5 * (1 << fw) + 50000) / 100000;
  endfunction

  function automatic phase_e next_phase(input phase_e ph);
    case (ph)
      PH_Y0:   return PH_U;
      PH_U:    return PH_Y1;
      PH_Y1:   return PH_V;
      default: return PH_Y0;
    endcase
  endfunction

endpackage

// File: rtl/yuv_grp_collect.sv
module yuv_grp_collect
  import yuv_rgb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              grp_vld_o,
  output logic [DATA_W-1:0] y0_o,
  output logic [DATA_W-1:0] u_o,
  output logic [DATA_W-1:0] y1_o,
  output logic [DATA_W-1:0] v_o
);

  phase_e            phase_q, cur_ph, phase_d;
  logic              grp_vld_q;
  logic [DATA_W-1:0] y0_q, u_q, y1_q, v_q;

  always_comb begin
    cur_ph  = sof_i ? PH_Y0 : phase_q;
    phase_d = phase_q;
    if (vld_i)      phase_d = next_phase(cur_ph);
    else if (sof_i) phase_d = PH_Y0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_Y0;
      grp_vld_q <= 1'b0;
      y0_q      <= '0;
      u_q       <= '0;
      y1_q      <= '0;
      v_q       <= '0;
    end else begin
      phase_q   <= phase_d;
      grp_vld_q <= vld_i && (cur_ph == PH_V);
      if (vld_i) begin
        case (cur_ph)
          PH_Y0:   y0_q <= byte_i;
          PH_U:    u_q  <= byte_i;
          PH_Y1:   y1_q <= byte_i;
          default: v_q  <= byte_i;
        endcase
      end
    end
  end

  assign grp_vld_o = grp_vld_q;
  assign y0_o      = y0_q;
  assign u_o       = u_q;
  assign y1_o      = y1_q;
  assign v_o       = v_q;

  AST_GRP_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_vld_q |-> $past(vld_i)); // R1
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !sof_i) |=> $stable(phase_q)); // R8
  AST_SOF_BYTE_Y0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && vld_i) |=> (phase_q == PH_U)); // R7
  AST_SOF_IDLE_Y0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !vld_i) |=> (phase_q == PH_Y0)); // R7

endmodule

// File: rtl/yuv_pix_seq.sv
module yuv_pix_seq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grp_vld_i,
  input  logic [DATA_W-1:0] y0_i,
  input  logic [DATA_W-1:0] u_i,
  input  logic [DATA_W-1:0] y1_i,
  input  logic [DATA_W-1:0] v_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] u_o,
  output logic [DATA_W-1:0] v_o
);

  logic              pend_q;
  logic [DATA_W-1:0] y1_q, u_q, v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      y1_q   <= '0;
      u_q    <= '0;
      v_q    <= '0;
    end else begin
      pend_q <= grp_vld_i;
      if (grp_vld_i) begin
        y1_q <= y1_i;
        u_q  <= u_i;
        v_q  <= v_i;
      end
    end
  end

  // First pixel straight from the group, second from the held copy
  assign vld_o = grp_vld_i | pend_q;
  assign y_o   = grp_vld_i ? y0_i : y1_q;
  assign u_o   = grp_vld_i ? u_i  : u_q;
  assign v_o   = grp_vld_i ? v_i  : v_q;

  AST_SEQ_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grp_vld_i && pend_q)); // R2
  AST_SEQ_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_vld_i |=> (vld_o && $stable(u_o) && $stable(v_o))); // R3

endmodule

// File: rtl/yuv_rgb_matrix.sv
module yuv_rgb_matrix
  import yuv_rgb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] u_i,
  input  logic [DATA_W-1:0] v_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] r_o,
  output logic [DATA_W-1:0] g_o,
  output logic [DATA_W-1:0] b_o
);

  localparam int unsigned CW = DATA_W + 1;
  localparam int unsigned KW = FRAC_W + 3;
  localparam int unsigned PW = CW + KW;
  localparam int unsigned RW = PW - FRAC_W;
  localparam int unsigned SW = RW + 2;

  localparam logic [CW-1:0]        OFS   = CW'(2 ** (DATA_W - 1));
  localparam logic signed [PW-1:0] HALF  = PW'(2 ** (FRAC_W - 1));
  localparam logic signed [KW-1:0] K_RV  = KW'(q_coef(140200, FRAC_W));
  localparam logic signed [KW-1:0] K_GU  = KW'(q_coef(34414, FRAC_W));
  localparam logic signed [KW-1:0] K_GV  = KW'(q_coef(71414, FRAC_W));
  localparam logic signed [KW-1:0] K_BU  = KW'(q_coef(177200, FRAC_W));

  function automatic logic signed [RW-1:0] rnd(input logic signed [PW-1:0] p);
    logic signed [PW-1:0] t;
    t = p + HALF;
    return t[PW-1:FRAC_W];
  endfunction

  function automatic logic signed [SW-1:0] sx(input logic signed [RW-1:0] t);
    return {{(SW - RW){t[RW-1]}}, t};
  endfunction

  function automatic logic [DATA_W-1:0] clamp(input logic signed [SW-1:0] s);
    if (s[SW-1])              return '0;
    if (|s[SW-2:DATA_W])      return '1;
    return s[DATA_W-1:0];
  endfunction

  logic signed [CW-1:0] cu, cv;
  logic signed [PW-1:0] p_rv, p_gu, p_gv, p_bu;
  logic signed [RW-1:0] t_rv, t_gu, t_gv, t_bu;
  logic signed [SW-1:0] ys, r_s, g_s, b_s;

  always_comb begin
    cu   = $signed({1'b0, u_i}) - $signed(OFS);
    cv   = $signed({1'b0, v_i}) - $signed(OFS);
    p_rv = cv * K_RV;
    p_gu = cu * K_GU;
    p_gv = cv * K_GV;
    p_bu = cu * K_BU;
    t_rv = rnd(p_rv);
    t_gu = rnd(p_gu);
    t_gv = rnd(p_gv);
    t_bu = rnd(p_bu);
    ys   = $signed({{(SW - DATA_W){1'b0}}, y_i});
    r_s  = ys + sx(t_rv);
    g_s  = ys - sx(t_gu) - sx(t_gv);
    b_s  = ys + sx(t_bu);
  end

  logic              vld_q;
  logic [DATA_W-1:0] r_q, g_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      r_q   <= '0;
      g_q   <= '0;
      b_q   <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        r_q <= clamp(r_s);
        g_q <= clamp(g_s);
        b_q <= clamp(b_s);
      end
    end
  end

  assign vld_o = vld_q;
  assign r_o   = r_q;
  assign g_o   = g_q;
  assign b_o   = b_q;

  AST_MTX_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o); // R2
  AST_MTX_NEUTRAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && u_i == OFS[DATA_W-1:0] && v_i == OFS[DATA_W-1:0])
      |=> (r_o == $past(y_i) && g_o == $past(y_i) && b_o == $past(y_i))); // R4

endmodule

// File: rtl/yuv422_rgb_conv.sv
module yuv422_rgb_conv #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned FRAC_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sof_i,
  input  logic                byte_vld_i,
  input  logic [DATA_W-1:0]   byte_i,
  output logic                pix_vld_o,
  output logic [3*DATA_W-1:0] pix_o
);

  logic              grp_vld;
  logic [DATA_W-1:0] g_y0, g_u, g_y1, g_v;
  logic              s_vld;
  logic [DATA_W-1:0] s_y, s_u, s_v;
  logic [DATA_W-1:0] r, g, b;

  yuv_grp_collect #(.DATA_W(DATA_W)) u_collect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sof_i     (sof_i),
    .vld_i     (byte_vld_i),
    .byte_i    (byte_i),
    .grp_vld_o (grp_vld),
    .y0_o      (g_y0),
    .u_o       (g_u),
    .y1_o      (g_y1),
    .v_o       (g_v)
  );

  yuv_pix_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .grp_vld_i (grp_vld),
    .y0_i      (g_y0),
    .u_i       (g_u),
    .y1_i      (g_y1),
    .v_i       (g_v),
    .vld_o     (s_vld),
    .y_o       (s_y),
    .u_o       (s_u),
    .v_o       (s_v)
  );

  yuv_rgb_matrix #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_matrix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s_vld),
    .y_i    (s_y),
    .u_i    (s_u),
    .v_i    (s_v),
    .vld_o  (pix_vld_o),
    .r_o    (r),
    .g_o    (g),
    .b_o    (b)
  );

  assign pix_o = {r, g, b};

  AST_PIX_MAX_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_o && $past(pix_vld_o)) |=> !pix_vld_o); // R2
  AST_PIX_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pix_vld_o) |-> $past(pix_vld_o, 2)); // R2

endmodule

// File: tb/yuv422_rgb_conv_bench.sv
module yuv422_rgb_conv_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sof_i = 1'b0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        pix_vld_o;
  logic [23:0] pix_o;

  always #5 clk_i = ~clk_i;

  yuv422_rgb_conv u_yuv422_rgb_conv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .pix_vld_o  (pix_vld_o),
    .pix_o      (pix_o)
  );

  typedef struct {
    int          cyc;
    logic [23:0] px;
  } exp_t;

  exp_t  exp_q[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  int    ph = 0;
  int    m_y0, m_u, m_y1;
  string tag = "R9";
  bit    done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // Reference arithmetic from the requirements (R4, R5, R6, R10)
  function automatic int rterm(real k, int c);
    int q;
    q = $rtoi(k * 256.0 + 0.5);
    return $rtoi($floor(real'(q * (c - 128)) / 256.0 + 0.5));
  endfunction

  function automatic int sat(int s);
    if (s < 0)   return 0;
    if (s > 255) return 255;
    return s;
  endfunction

  function automatic logic [23:0] ref_px(int y, int u, int v);
    int r, g, b;
    r = sat(y + rterm(1.402, v));
    g = sat(y - rterm(0.34414, u) - rterm(0.71414, v));
    b = sat(y + rterm(1.772, u));
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  // Drive one cycle; model the slot order (R1, R7, R8)
  task automatic drive(input bit vld, input bit sof, input int b);
    exp_t e;
    @(negedge clk_i);
    byte_vld_i = vld;
    sof_i      = sof;
    byte_i     = b[7:0];
    if (vld) begin
      if (sof) ph = 0;
      case (ph)
        0: m_y0 = b;
        1: m_u  = b;
        2: m_y1 = b;
        default: begin
          e.cyc = cyc + 2; e.px = ref_px(m_y0, m_u, b); exp_q.push_back(e);
          e.cyc = cyc + 3; e.px = ref_px(m_y1, m_u, b); exp_q.push_back(e);
        end
      endcase
      ph = (ph + 1) % 4;
    end else if (sof) begin
      ph = 0;
    end
  endtask

  task automatic group(input int y0, input int u, input int y1, input int v);
    drive(1'b1, 1'b0, y0);
    drive(1'b1, 1'b0, u);
    drive(1'b1, 1'b0, y1);
    drive(1'b1, 1'b0, v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, $urandom_range(0, 255));
  endtask

  // Cycle-by-cycle comparison at the falling edge
  always @(negedge clk_i) begin
    if (!done) begin
      if (!rst_ni) begin
        n_cmp++;
        if (pix_vld_o !== 1'b0) begin
          n_bad++;
          $display("FAIL R9 reset: pix_vld_o=%b expected 0", pix_vld_o);
        end
      end else if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
        n_cmp++;
        if (pix_vld_o !== 1'b1 || pix_o !== exp_q[0].px) begin
          n_bad++;
          $display("FAIL %s R2 R3 R4 R5 R6 R10 cyc %0d: vld=%b pix=%h expected vld=1 pix=%h",
                   tag, cyc, pix_vld_o, pix_o, exp_q[0].px);
        end
        void'(exp_q.pop_front());
      end else begin
        n_cmp++;
        if (pix_vld_o !== 1'b0) begin
          n_bad++;
          $display("FAIL %s R1 R2 cyc %0d: vld=%b expected 0", tag, cyc, pix_vld_o);
        end
      end
    end
  end

  task automatic drain;
    idle(6);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    // R9: reset holds output low
    idle(4);
    @(negedge clk_i) rst_ni = 1'b1;
    idle(3);

    // R4: neutral chroma, R3: distinct luma share one chroma pair
    tag = "R4";
    group(128, 128, 77, 128);
    group(16, 128, 235, 128);
    drain();
    tag = "R3";
    group(10, 200, 250, 60);
    group(200, 30, 90, 220);
    drain();

    // R6: both clamp limits on all channels
    tag = "R6";
    group(0, 0, 255, 255);
    group(255, 255, 0, 0);
    group(0, 255, 255, 0);
    drain();

    // R5: values sitting near rounding halves
    tag = "R5";
    for (int c = 120; c < 137; c++) group(100, c, 101, 255 - c);
    drain();

    // R8: gaps with garbage on the byte lines
    tag = "R8";
    drive(1'b1, 1'b0, 50); idle(3);
    drive(1'b1, 1'b0, 180); idle(1);
    drive(1'b1, 1'b0, 60); idle(5);
    drive(1'b1, 1'b0, 40);
    drain();

    // R7: restart mid-group with and without a byte, then at every phase
    tag = "R7";
    drive(1'b1, 1'b0, 11); drive(1'b1, 1'b0, 22);
    drive(1'b1, 1'b1, 33); drive(1'b1, 1'b0, 44); drive(1'b1, 1'b0, 55); drive(1'b1, 1'b0, 66);
    drive(1'b1, 1'b0, 1); drive(1'b1, 1'b0, 2); drive(1'b1, 1'b0, 3);
    drive(1'b0, 1'b1, 0);
    group(70, 140, 210, 20);
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < p; i++) drive(1'b1, 1'b0, 99);
      drive(1'b1, 1'b1, 120 + p);
      drive(1'b1, 1'b0, 30);
      drive(1'b1, 1'b0, 130);
      drive(1'b1, 1'b0, 230);
    end
    drain();

    // R1: long random stream with gaps and occasional restarts
    tag = "R1";
    for (int i = 0; i < 6000; i++) begin
      bit v;
      bit s;
      v = ($urandom_range(0, 3) != 0);
      s = ($urandom_range(0, 199) == 0);
      drive(v, s, $urandom_range(0, 255));
    end
    drain();

    // R1: one small dense frame back to back
    tag = "R1";
    drive(1'b0, 1'b1, 0);
    for (int i = 0; i < 256; i++) drive(1'b1, 1'b0, (i * 37 + 11) % 256);
    drain();

    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 pending: %0d pixels not seen, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule